// File: doc/BRIEF.md
# SD/MMC Card Response Receiver

This block listens on the command line of an SD/MMC host after the host has finished sending a command. It looks for the start of the card's reply and shifts the reply in one bit per sample-enable pulse. The reply is either a short 48-bit frame or a long 136-bit frame. When the frame is complete, the block presents the payload and reports framing, CRC and index errors. If no reply begins in time, it reports a timeout instead.

Each command carries a small configuration that is latched with the command-end pulse. A 2-bit response kind gives the frame length or says that no reply is expected. Two enables select whether the 7-bit CRC and the echoed command index are checked. The busy kind adds a wait after the frame: the block holds a busy indication until the card releases data line 0, and only then raises done.

Top module: `rsp_token_rx`

## Requirements
- R1: While reset is held and after it is released, done, busy_wait, all four error flags, rsp_data and rsp_idx are 0.
- R2: Response kind encoding is 00 none, 01 long 136-bit, 10 short 48-bit, 11 short 48-bit with busy. With kind 00, done is high in the cycle after the cmd_end pulse and every error flag is 0.
- R3: A short frame, first bit first, is: start bit 0, direction bit, 6-bit index, 32-bit argument, 7-bit CRC, end bit. After it ends, rsp_data[31:0] holds the argument, rsp_data[119:32] is 0, rsp_idx holds the received index, and done rises unless the kind is 11.
- R4: A long frame is: an 8-bit header (start bit, direction bit, six reserved bits), 120 payload bits, a 7-bit CRC and an end bit. After it ends, rsp_data holds the 120 payload bits with the first received bit at bit 119, and rsp_idx is 0.
- R5: The CRC uses the polynomial x^7+x^3+1 and starts from zero. It covers the first 40 bits of a short frame, and only the 120 payload bits of a long frame. When the CRC enable is set and the received CRC differs from the computed one, crc_err is set. When the enable is clear, crc_err stays 0.
- R6: For short frames with the index enable set, idx_err is set when the received index differs from the command index latched at cmd_end. For long frames, and when the enable is clear, idx_err stays 0.
- R7: frm_err is set when the final bit of the frame is 0 or the direction bit is 1. These checks do not depend on the enables.
- R8: In the waiting state, each sample pulse with the command line high is counted. If 64 such pulses pass without a start bit, tmo_err and done rise and the other error flags stay 0. A start bit on the 64th pulse or earlier is accepted.
- R9: For kind 11, busy_wait is high from the end of the frame until a sample pulse sees data line 0 high. done rises in the next cycle and busy_wait falls.
- R10: A cmd_end pulse clears done, the flags and the outputs, and restarts reception, even in the middle of a frame. Sample pulses while idle leave every output unchanged until the next cmd_end.
- R11: done and busy_wait are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | One-cycle pulse that samples the card lines |
| cmd_end | input | 1 | Pulse at the end of the issued command; latches the configuration |
| cfg_kind | input | 2 | Response kind (00 none, 01 long, 10 short, 11 short with busy) |
| cfg_crc_en | input | 1 | Enables the CRC check |
| cfg_idx_en | input | 1 | Enables the index check |
| cfg_cmd_idx | input | 6 | Index of the issued command |
| cmd_in | input | 1 | Command line from the card |
| dat0_in | input | 1 | Data line 0 from the card (low while busy) |
| rsp_data | output | 120 | Captured payload |
| rsp_idx | output | 6 | Echoed index of a short frame |
| done | output | 1 | Response finished; held until the next cmd_end |
| busy_wait | output | 1 | Waiting for data line 0 to be released |
| crc_err | output | 1 | CRC mismatch |
| idx_err | output | 1 | Index mismatch |
| frm_err | output | 1 | Bad end bit or bad direction bit |
| tmo_err | output | 1 | No start bit within the limit |

## Verification
A bit counter that is off by one moves the point at which done rises. It also shifts every captured field by one place, so rsp_data, rsp_idx and the CRC verdict are wrong as soon as the frame completes. A wrong CRC window or a CRC register that is not cleared gives a false crc_err on a clean frame at the same moment. A faulty wait counter shows up on the 64th idle pulse as a premature or missing tmo_err. A faulty busy state shows up as done rising before data line 0 is released.

// File: rtl/rsp_rx_pkg.sv
package rsp_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RECV,
    ST_EVAL,
    ST_BUSY
  } rx_state_e;

  localparam logic [1:0] KIND_NONE  = 2'b00;
  localparam logic [1:0] KIND_LONG  = 2'b01;
  localparam logic [1:0] KIND_SHORT = 2'b10;
  localparam logic [1:0] KIND_BUSY  = 2'b11;
endpackage

// File: rtl/rsp_rst_sync.sv
module rsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rsp_crc7.sv
module rsp_crc7 #(
  parameter int CRC_W = 7,
  parameter logic [CRC_W-1:0] POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    fb    = crc_q[CRC_W-1] ^ bit_in;
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (upd) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
  import rsp_rx_pkg::*;
#(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int HDR_LEN   = 8,
  parameter int CRC_W     = 7,
  parameter int IDX_W     = 6,
  parameter int TMO_LIM   = 64,
  localparam int CNT_W    = $clog2(LONG_LEN),
  localparam int TMO_W    = $clog2(TMO_LIM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             cmd_end,
  input  logic [1:0]       cfg_kind,
  input  logic             cfg_crc_en,
  input  logic             cfg_idx_en,
  input  logic [IDX_W-1:0] cfg_cmd_idx,
  input  logic             cmd_in,
  input  logic             dat0_in,
  output logic             shift_en,
  output logic             crc_upd,
  output logic [CNT_W-1:0] bit_pos,
  output logic             eval,
  output logic             is_long,
  output logic             crc_chk,
  output logic             idx_chk,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             done,
  output logic             busy_wait,
  output logic             tmo_err
);
  localparam int SHORT_WIN = SHORT_LEN - CRC_W - 1;
  localparam int LONG_WIN  = LONG_LEN - CRC_W - 1;

  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [TMO_W-1:0] wcnt_q, wcnt_d;
  logic [1:0]       kind_q, kind_d;
  logic             crce_q, crce_d, idxe_q, idxe_d;
  logic [IDX_W-1:0] cidx_q, cidx_d;
  logic             done_q, done_d, tmo_q, tmo_d;
  logic [CNT_W-1:0] last_pos;
  logic             in_win;

  assign is_long  = (kind_q == KIND_LONG);
  assign last_pos = is_long ? CNT_W'(LONG_LEN - 1) : CNT_W'(SHORT_LEN - 1);

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    wcnt_d = wcnt_q;
    kind_d = kind_q;
    crce_d = crce_q;
    idxe_d = idxe_q;
    cidx_d = cidx_q;
    done_d = done_q;
    tmo_d  = tmo_q;
    if (cmd_end) begin
      kind_d = cfg_kind;
      crce_d = cfg_crc_en;
      idxe_d = cfg_idx_en;
      cidx_d = cfg_cmd_idx;
      pos_d  = '0;
      wcnt_d = '0;
      tmo_d  = 1'b0;
      if (cfg_kind == KIND_NONE) begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end else begin
        done_d = 1'b0;
        st_d   = ST_WAIT;
      end
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (smp_en) begin
            if (!cmd_in) begin
              st_d  = ST_RECV;
              pos_d = CNT_W'(1);
            end else if (wcnt_q == TMO_W'(TMO_LIM - 1)) begin
              tmo_d  = 1'b1;
              done_d = 1'b1;
              st_d   = ST_IDLE;
            end else begin
              wcnt_d = wcnt_q + TMO_W'(1);
            end
          end
        end
        ST_RECV: begin
          if (smp_en) begin
            if (pos_q == last_pos) st_d = ST_EVAL;
            else                   pos_d = pos_q + CNT_W'(1);
          end
        end
        ST_EVAL: begin
          if (kind_q == KIND_BUSY) begin
            st_d = ST_BUSY;
          end else begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (smp_en && dat0_in) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      wcnt_q <= '0;
      kind_q <= KIND_NONE;
      crce_q <= 1'b0;
      idxe_q <= 1'b0;
      cidx_q <= '0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      wcnt_q <= wcnt_d;
      kind_q <= kind_d;
      crce_q <= crce_d;
      idxe_q <= idxe_d;
      cidx_q <= cidx_d;
      done_q <= done_d;
      tmo_q  <= tmo_d;
    end
  end

  always_comb begin
    bit_pos  = (st_q == ST_RECV) ? pos_q : '0;
    shift_en = smp_en && !cmd_end &&
               (((st_q == ST_WAIT) && !cmd_in) || (st_q == ST_RECV));
    if (is_long) in_win = (bit_pos >= CNT_W'(HDR_LEN)) && (bit_pos < CNT_W'(LONG_WIN));
    else         in_win = (bit_pos < CNT_W'(SHORT_WIN));
    crc_upd  = shift_en && in_win;
  end

  assign eval      = (st_q == ST_EVAL) && !cmd_end;
  assign crc_chk   = crce_q;
  assign idx_chk   = idxe_q && !is_long;
  assign cmd_idx   = cidx_q;
  assign done      = done_q;
  assign busy_wait = (st_q == ST_BUSY);
  assign tmo_err   = tmo_q;
endmodule

// File: rtl/rsp_frame.sv
module rsp_frame #(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int HDR_LEN   = 8,
  parameter int CRC_W     = 7,
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  localparam int CNT_W    = $clog2(LONG_LEN),
  localparam int SR_W     = LONG_LEN - HDR_LEN,
  localparam int PAY_W    = SR_W - CRC_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_end,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] bit_pos,
  input  logic             eval,
  input  logic             is_long,
  input  logic             crc_chk,
  input  logic             idx_chk,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [CRC_W-1:0] crc_calc,
  output logic [PAY_W-1:0] rsp_data,
  output logic [IDX_W-1:0] rsp_idx,
  output logic             crc_err,
  output logic             idx_err,
  output logic             frm_err
);
  logic [SR_W-1:0]  sr_q, sr_d;
  logic             dir_q, dir_d;
  logic [PAY_W-1:0] data_q, data_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             crce_q, crce_d, idxe_q, idxe_d, frme_q, frme_d;
  logic [IDX_W-1:0] rx_idx;
  logic [CRC_W-1:0] rx_crc;

  assign rx_idx = sr_q[SHORT_LEN-3 -: IDX_W];
  assign rx_crc = sr_q[CRC_W:1];

  always_comb begin
    sr_d   = sr_q;
    dir_d  = dir_q;
    data_d = data_q;
    idx_d  = idx_q;
    crce_d = crce_q;
    idxe_d = idxe_q;
    frme_d = frme_q;
    if (cmd_end) begin
      sr_d   = '1;
      dir_d  = 1'b0;
      data_d = '0;
      idx_d  = '0;
      crce_d = 1'b0;
      idxe_d = 1'b0;
      frme_d = 1'b0;
    end else if (eval) begin
      if (is_long) begin
        data_d = sr_q[SR_W-1 -: PAY_W];
        idx_d  = '0;
      end else begin
        data_d = PAY_W'(sr_q[CRC_W+ARG_W -: ARG_W]);
        idx_d  = rx_idx;
      end
      crce_d = crc_chk && (rx_crc != crc_calc);
      idxe_d = idx_chk && (rx_idx != cmd_idx);
      frme_d = !sr_q[0] || dir_q;
    end else if (shift_en) begin
      sr_d = {sr_q[SR_W-2:0], bit_in};
      if (bit_pos == CNT_W'(1)) dir_d = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      dir_q  <= 1'b0;
      data_q <= '0;
      idx_q  <= '0;
      crce_q <= 1'b0;
      idxe_q <= 1'b0;
      frme_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      dir_q  <= dir_d;
      data_q <= data_d;
      idx_q  <= idx_d;
      crce_q <= crce_d;
      idxe_q <= idxe_d;
      frme_q <= frme_d;
    end
  end

  assign rsp_data = data_q;
  assign rsp_idx  = idx_q;
  assign crc_err  = crce_q;
  assign idx_err  = idxe_q;
  assign frm_err  = frme_q;
endmodule

// File: rtl/rsp_token_rx.sv
module rsp_token_rx #(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int HDR_LEN   = 8,
  parameter int CRC_W     = 7,
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int TMO_LIM   = 64,
  localparam int CNT_W    = $clog2(LONG_LEN),
  localparam int PAY_W    = LONG_LEN - HDR_LEN - CRC_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             cmd_end,
  input  logic [1:0]       cfg_kind,
  input  logic             cfg_crc_en,
  input  logic             cfg_idx_en,
  input  logic [IDX_W-1:0] cfg_cmd_idx,
  input  logic             cmd_in,
  input  logic             dat0_in,
  output logic [PAY_W-1:0] rsp_data,
  output logic [IDX_W-1:0] rsp_idx,
  output logic             done,
  output logic             busy_wait,
  output logic             crc_err,
  output logic             idx_err,
  output logic             frm_err,
  output logic             tmo_err
);
  logic             rst_n_s;
  logic             shift_en, crc_upd, eval, is_long, crc_chk, idx_chk;
  logic [CNT_W-1:0] bit_pos;
  logic [IDX_W-1:0] cmd_idx;
  logic [CRC_W-1:0] crc_calc;

  rsp_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  rsp_ctrl #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .HDR_LEN(HDR_LEN),
    .CRC_W(CRC_W), .IDX_W(IDX_W), .TMO_LIM(TMO_LIM)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .smp_en     (smp_en),
    .cmd_end    (cmd_end),
    .cfg_kind   (cfg_kind),
    .cfg_crc_en (cfg_crc_en),
    .cfg_idx_en (cfg_idx_en),
    .cfg_cmd_idx(cfg_cmd_idx),
    .cmd_in     (cmd_in),
    .dat0_in    (dat0_in),
    .shift_en   (shift_en),
    .crc_upd    (crc_upd),
    .bit_pos    (bit_pos),
    .eval       (eval),
    .is_long    (is_long),
    .crc_chk    (crc_chk),
    .idx_chk    (idx_chk),
    .cmd_idx    (cmd_idx),
    .done       (done),
    .busy_wait  (busy_wait),
    .tmo_err    (tmo_err)
  );

  rsp_crc7 #(.CRC_W(CRC_W)) u_crc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (cmd_end),
    .upd   (crc_upd),
    .bit_in(cmd_in),
    .crc   (crc_calc)
  );

  rsp_frame #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .HDR_LEN(HDR_LEN),
    .CRC_W(CRC_W), .IDX_W(IDX_W), .ARG_W(ARG_W)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cmd_end (cmd_end),
    .shift_en(shift_en),
    .bit_in  (cmd_in),
    .bit_pos (bit_pos),
    .eval    (eval),
    .is_long (is_long),
    .crc_chk (crc_chk),
    .idx_chk (idx_chk),
    .cmd_idx (cmd_idx),
    .crc_calc(crc_calc),
    .rsp_data(rsp_data),
    .rsp_idx (rsp_idx),
    .crc_err (crc_err),
    .idx_err (idx_err),
    .frm_err (frm_err)
  );
endmodule

// File: rtl/rsp_token_rx_chk.sv
module rsp_token_rx_chk #(
  parameter int PAY_W = 120,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_en,
  input logic             cmd_end,
  input logic [1:0]       cfg_kind,
  input logic             dat0_in,
  input logic [PAY_W-1:0] rsp_data,
  input logic [IDX_W-1:0] rsp_idx,
  input logic             done,
  input logic             busy_wait,
  input logic             crc_err,
  input logic             idx_err,
  input logic             frm_err,
  input logic             tmo_err
);
  assert_done_busy_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy_wait));

  assert_tmo_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (done && !crc_err && !idx_err && !frm_err));

  assert_no_rsp_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && cfg_kind == 2'b00) |=> (done && !crc_err && !idx_err && !frm_err && !tmo_err));

  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && cfg_kind != 2'b00) |=> (!done && !crc_err && !idx_err && !frm_err && !tmo_err));

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_end) |=> (done && $stable(rsp_data) && $stable(rsp_idx) && $stable(crc_err)));

  assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_wait && smp_en && dat0_in && !cmd_end) |=> (done && !busy_wait));
endmodule

bind rsp_token_rx rsp_token_rx_chk #(.PAY_W(PAY_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_rsp_token_rx.sv
module sim_rsp_token_rx;
  typedef struct packed {
    logic [1:0]  kind;
    logic        ce;
    logic        ie;
    logic [5:0]  cidx;
    logic [5:0]  ridx;
    logic [31:0] arg;
    logic [6:0]  pre;
    logic        flip_crc;
    logic        bad_end;
    logic        bad_dir;
    logic [3:0]  busy;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{2'b10, 1'b1, 1'b1, 6'd17, 6'd17, 32'h1234_5678, 7'd3,  1'b0, 1'b0, 1'b0, 4'd0},
    '{2'b10, 1'b1, 1'b1, 6'd17, 6'd18, 32'hCAFE_0001, 7'd0,  1'b0, 1'b0, 1'b0, 4'd0},
    '{2'b10, 1'b1, 1'b0, 6'd5,  6'd5,  32'h0F0F_A5A5, 7'd1,  1'b1, 1'b0, 1'b0, 4'd0},
    '{2'b10, 1'b0, 1'b0, 6'd41, 6'h3F, 32'h00FF_8000, 7'd2,  1'b1, 1'b0, 1'b0, 4'd0},
    '{2'b01, 1'b1, 1'b1, 6'd2,  6'd9,  32'h89AB_CDEF, 7'd0,  1'b0, 1'b0, 1'b0, 4'd0},
    '{2'b01, 1'b1, 1'b0, 6'd2,  6'd2,  32'h1357_9BDF, 7'd4,  1'b1, 1'b0, 1'b0, 4'd0},
    '{2'b11, 1'b1, 1'b1, 6'd7,  6'd7,  32'h0000_0900, 7'd2,  1'b0, 1'b0, 1'b0, 4'd5},
    '{2'b10, 1'b1, 1'b1, 6'd12, 6'd12, 32'hDEAD_BEEF, 7'd0,  1'b0, 1'b1, 1'b0, 4'd0},
    '{2'b10, 1'b1, 1'b1, 6'd3,  6'd3,  32'h7777_1111, 7'd63, 1'b0, 1'b0, 1'b1, 4'd0},
    '{2'b01, 1'b0, 1'b0, 6'd2,  6'd2,  32'hFFFF_0000, 7'd1,  1'b1, 1'b0, 1'b0, 4'd0},
    '{2'b11, 1'b1, 1'b1, 6'd55, 6'd55, 32'h0000_0001, 7'd0,  1'b0, 1'b0, 1'b0, 4'd0}
  };

  logic         clk;
  logic         rst_n, smp_en, cmd_end, cfg_crc_en, cfg_idx_en, cmd_in, dat0_in;
  logic [1:0]   cfg_kind;
  logic [5:0]   cfg_cmd_idx;
  logic [119:0] rsp_data;
  logic [5:0]   rsp_idx;
  logic         done, busy_wait, crc_err, idx_err, frm_err, tmo_err;
  int           n_chk, n_fail;

  rsp_token_rx u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .cmd_end(cmd_end),
    .cfg_kind(cfg_kind), .cfg_crc_en(cfg_crc_en), .cfg_idx_en(cfg_idx_en),
    .cfg_cmd_idx(cfg_cmd_idx), .cmd_in(cmd_in), .dat0_in(dat0_in),
    .rsp_data(rsp_data), .rsp_idx(rsp_idx), .done(done), .busy_wait(busy_wait),
    .crc_err(crc_err), .idx_err(idx_err), .frm_err(frm_err), .tmo_err(tmo_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7_ref(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = hi; i >= lo; i--) begin
      fb = c[6] ^ v[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic pulse(input logic b);
    @(negedge clk); cmd_in = b; smp_en = 1'b1;
    @(negedge clk); smp_en = 1'b0; cmd_in = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] k, input logic ce, input logic ie, input logic [5:0] ci);
    @(negedge clk);
    cfg_kind = k; cfg_crc_en = ce; cfg_idx_en = ie; cfg_cmd_idx = ci; cmd_end = 1'b1;
    @(negedge clk); cmd_end = 1'b0;
  endtask

  function automatic logic [119:0] long_pay(input logic [31:0] a);
    return {a, ~a, a ^ 32'h5A5A_C3C3, a[23:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [135:0] fr;
    logic [119:0] pay;
    logic [119:0] exp_data;
    logic [5:0]   exp_idx;
    int           flen;
    vec_t         v;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; smp_en = 1'b0; cmd_end = 1'b0; cfg_kind = 2'b00;
    cfg_crc_en = 1'b0; cfg_idx_en = 1'b0; cfg_cmd_idx = '0; cmd_in = 1'b1; dat0_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {127'b0, done}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 flags after reset", {123'b0, done, busy_wait, crc_err, idx_err, frm_err}, 128'd0);
    chk("R1 tmo after reset", {127'b0, tmo_err}, 128'd0);
    chk("R1 data after reset", {2'b0, rsp_idx, rsp_data}, 128'd0);

    for (int n = 0; n < NV; n++) begin
      v = VT[n];
      fr = '1;
      if (v.kind == 2'b01) begin
        flen = 136;
        pay  = long_pay(v.arg);
        fr[135:128] = {1'b0, v.bad_dir, 6'h3F};
        fr[127:8]   = pay;
        fr[7:1]     = crc7_ref(fr, 127, 8) ^ {6'b0, v.flip_crc};
        fr[0]       = ~v.bad_end;
        exp_data    = pay;
        exp_idx     = '0;
      end else begin
        flen = 48;
        fr[47]    = 1'b0;
        fr[46]    = v.bad_dir;
        fr[45:40] = v.ridx;
        fr[39:8]  = v.arg;
        fr[7:1]   = crc7_ref(fr, 47, 8) ^ {6'b0, v.flip_crc};
        fr[0]     = ~v.bad_end;
        exp_data  = {88'b0, v.arg};
        exp_idx   = v.ridx;
      end
      issue(v.kind, v.ce, v.ie, v.cidx);
      chk($sformatf("R10 vec%0d done cleared", n), {127'b0, done}, 128'd0);
      for (int p = 0; p < int'(v.pre); p++) pulse(1'b1);
      if (v.kind == 2'b11) dat0_in = 1'b0;
      for (int i = flen - 1; i >= 0; i--) pulse(fr[i]);
      if (v.kind == 2'b11) begin
        chk($sformatf("R9 vec%0d busy_wait", n), {126'b0, busy_wait, done}, 128'd2);
        for (int b = 0; b < int'(v.busy); b++) pulse(1'b1);
        chk($sformatf("R9 vec%0d still busy", n), {126'b0, busy_wait, done}, 128'd2);
        dat0_in = 1'b1;
        pulse(1'b1);
        chk($sformatf("R9 vec%0d released", n), {126'b0, busy_wait, done}, 128'd1);
      end else begin
        chk($sformatf("R3 R4 vec%0d done", n), {126'b0, busy_wait, done}, 128'd1);
      end
      chk($sformatf("R3 R4 vec%0d data", n), {8'b0, rsp_data}, {8'b0, exp_data});
      chk($sformatf("R3 R4 vec%0d index", n), {122'b0, rsp_idx}, {122'b0, exp_idx});
      chk($sformatf("R5 vec%0d crc_err", n), {127'b0, crc_err}, {127'b0, v.ce && v.flip_crc});
      chk($sformatf("R6 vec%0d idx_err", n), {127'b0, idx_err},
          {127'b0, v.ie && (v.kind != 2'b01) && (v.ridx != v.cidx)});
      chk($sformatf("R7 vec%0d frm_err", n), {127'b0, frm_err}, {127'b0, v.bad_end || v.bad_dir});
      chk($sformatf("R8 vec%0d tmo_err", n), {127'b0, tmo_err}, 128'd0);
    end

    issue(2'b00, 1'b1, 1'b1, 6'd0);
    chk("R2 no-response done", {123'b0, done, crc_err, idx_err, frm_err, tmo_err}, 128'h10);

    issue(2'b10, 1'b1, 1'b1, 6'd9);
    for (int p = 0; p < 63; p++) pulse(1'b1);
    chk("R8 no timeout after 63", {126'b0, done, tmo_err}, 128'd0);
    pulse(1'b1);
    chk("R8 timeout after 64", {123'b0, done, crc_err, idx_err, frm_err, tmo_err}, 128'h11);

    for (int p = 0; p < 4; p++) pulse(1'b0);
    chk("R10 idle pulses ignored", {126'b0, done, tmo_err}, 128'd3);
    chk("R10 idle data unchanged", {2'b0, rsp_idx, rsp_data}, 128'd0);

    issue(2'b10, 1'b1, 1'b1, 6'd33);
    fr = '1;
    fr[47] = 1'b0; fr[46] = 1'b0; fr[45:40] = 6'd33; fr[39:8] = 32'hA1B2_C3D4;
    fr[7:1] = crc7_ref(fr, 47, 8); fr[0] = 1'b1;
    for (int i = 47; i >= 28; i--) pulse(~fr[i] | (i == 47 ? 1'b0 : 1'b0));
    issue(2'b10, 1'b1, 1'b1, 6'd33);
    chk("R10 restart clears", {126'b0, done, tmo_err}, 128'd0);
    for (int i = 47; i >= 0; i--) pulse(fr[i]);
    chk("R10 restart done", {123'b0, done, crc_err, idx_err, frm_err, tmo_err}, 128'h10);
    chk("R10 restart data", {8'b0, rsp_data}, {96'b0, 32'hA1B2_C3D4});
    chk("R11 done without busy", {127'b0, busy_wait}, 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule